// File: doc/BRIEF.md
# Lockable UART Control Register Bank with Identity Readback

This block is the host-facing register bank of a UART-style peripheral. A host does byte writes and byte reads by address. Two divisor bytes, three mixed control registers, a modem-control register, a feature register and two auxiliary bytes live here. The serial engine, the FIFOs and the baud generator are outside it.

Some upper bit groups are "extended" controls. They accept writes only while the unlock bit (bit 4) of the feature register is 1. Clearing that bit freezes the extended groups at their current values. The ordinary bits that share a byte with them stay writable. Two read-only addresses return a fixed device identity (0x04) and a revision code (0x01, the first revision). Both are visible only while the two divisor bytes are zero, so an active baud setting hides them.

Read data is registered. `rd_data` shows the register selected by `addr` at the previous rising clock edge.

Top module: `ureg_lock_top`

Address map and extended (lockable) bit groups:

| Address | Register | Lockable bits |
|---|---|---|
| 0 | divisor low | none |
| 1 | divisor high | none |
| 2 | interrupt enable | 7:4 |
| 3 | FIFO control | 5:4 |
| 4 | interrupt status config | 5:4 |
| 5 | modem control | 7:5 |
| 6 | feature (bit 4 unlock, bit 5 special-character detect, bits 3:0 flow select) | none |
| 7 | auxiliary A | 7:0 |
| 8 | auxiliary B | 7:0 |
| 9 | identity (read-only) | — |
| 10 | revision (read-only) | — |
| 11–15 | unmapped | — |

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls, every register at addresses 0–8 holds 0x00 and `rd_data` is 0x00. Bits 4 and 5 of the feature register are therefore 0 after reset.
- R2: A write to addresses 0–8 always updates the bits that are not in the register's lockable group, whatever the unlock bit holds.
- R3: While feature bit 4 is 1, a write updates the lockable bits of addresses 2, 3, 4, 5, 7 and 8.
- R4: While feature bit 4 is 0, a write leaves the lockable bits of those addresses at their previous values.
- R5: The feature register at address 6 is always fully writable and readable. Writing it with bit 4 cleared locks the extended groups from the next write on.
- R6: A read of address 9 returns 0x04 when addresses 0 and 1 both hold 0x00.
- R7: A read of address 10 returns 0x01 when addresses 0 and 1 both hold 0x00.
- R8: When address 0 or address 1 is nonzero, reads of addresses 9 and 10 return 0x00.
- R9: Writes to addresses 9–15 change no register, and reads of addresses 11–15 return 0x00.
- R10: `rd_data` is registered. It changes only at a rising edge, and then shows the register selected by `addr` just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| addr | input | 4 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |

## Verification
If a lockable bit has the wrong internal state, it shows at the next read of its address, one cycle after `addr` selects it. The same holds if a write leaks past the lock or a legacy bit is frozen by mistake. A wrong unlock flag shows differently: the feature readback stays right, but the next protected write goes to the wrong value. The identity gate depends on the divisor bytes, so a bad comparison shows as 0x04 or 0x01 where 0x00 is due, or the reverse, on the first read of address 9 or 10 after a divisor change.

// File: rtl/ureg_pkg.sv
package ureg_pkg;
  localparam int DW   = 8;
  localparam int AW   = 4;
  localparam int NREG = 9;

  localparam logic [AW-1:0] ADR_DIVLO = 4'd0;
  localparam logic [AW-1:0] ADR_DIVHI = 4'd1;
  localparam logic [AW-1:0] ADR_FEAT  = 4'd6;
  localparam logic [AW-1:0] ADR_ID    = 4'd9;
  localparam logic [AW-1:0] ADR_REV   = 4'd10;

  localparam int FEAT_IDX   = 6;
  localparam int UNLOCK_BIT = 4;

  localparam logic [DW-1:0] ID_CODE  = 8'h04;
  localparam logic [DW-1:0] REV_CODE = 8'h01;

  // lockable bit groups per register index
  function automatic logic [DW-1:0] lock_mask(input int idx);
    case (idx)
      2:       lock_mask = 8'hF0;
      3:       lock_mask = 8'h30;
      4:       lock_mask = 8'h30;
      5:       lock_mask = 8'hE0;
      7:       lock_mask = 8'hFF;
      8:       lock_mask = 8'hFF;
      default: lock_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ureg_decode.sv
module ureg_decode #(
  parameter int AW   = 4,
  parameter int NREG = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] wr_sel
);
  always_comb begin
    wr_sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (wr_en && (addr == AW'(i))) wr_sel[i] = 1'b1;
    end
  end

  // R9
  wr_sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

  // R9
  wr_sel_range_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || (int'(addr) >= NREG)) |-> (wr_sel == '0));
endmodule

// File: rtl/ureg_field.sv
module ureg_field #(
  parameter int          W     = 8,
  parameter logic [W-1:0] PMASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         unlock,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  logic [W-1:0] prot_nxt;

  always_comb prot_nxt = unlock ? wd : q;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= (wd & ~PMASK) | (prot_nxt & PMASK);
  end

  // R1
  field_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == '0));

  // R2
  legacy_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q & ~PMASK) == ($past(wd) & ~PMASK)));

  // R3
  unlocked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && unlock) |=> ((q & PMASK) == ($past(wd) & PMASK)));

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !unlock) |=> ((q & PMASK) == ($past(q) & PMASK)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/ureg_idgate.sv
module ureg_idgate #(
  parameter int            DW       = 8,
  parameter int            AW       = 4,
  parameter logic [AW-1:0] A_ID     = 4'd9,
  parameter logic [AW-1:0] A_REV    = 4'd10,
  parameter logic [DW-1:0] ID_VAL   = 8'h04,
  parameter logic [DW-1:0] REV_VAL  = 8'h01
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] div_lo,
  input  logic [DW-1:0] div_hi,
  output logic          hit,
  output logic [DW-1:0] val
);
  logic div_zero;

  always_comb begin
    div_zero = (div_lo == '0) && (div_hi == '0);
    hit      = (addr == A_ID) || (addr == A_REV);
    if (!div_zero)          val = '0;
    else if (addr == A_ID)  val = ID_VAL;
    else if (addr == A_REV) val = REV_VAL;
    else                    val = '0;
  end
endmodule

// File: rtl/ureg_lock_top.sv
module ureg_lock_top
  import ureg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [NREG-1:0] wr_sel;
  logic [DW-1:0]   regq [NREG];
  logic            unlock;
  logic            id_hit;
  logic [DW-1:0]   id_val;
  logic [DW-1:0]   rd_nxt;

  ureg_decode #(.AW(AW), .NREG(NREG)) i_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_sel(wr_sel)
  );

  assign unlock = regq[FEAT_IDX][UNLOCK_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    ureg_field #(.W(DW), .PMASK(lock_mask(g))) i_fld (
      .clk(clk), .rst(rst), .we(wr_sel[g]), .unlock(unlock),
      .wd(wr_data), .q(regq[g])
    );
  end

  ureg_idgate #(
    .DW(DW), .AW(AW), .A_ID(ADR_ID), .A_REV(ADR_REV),
    .ID_VAL(ID_CODE), .REV_VAL(REV_CODE)
  ) i_id (
    .addr(addr), .div_lo(regq[0]), .div_hi(regq[1]),
    .hit(id_hit), .val(id_val)
  );

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == AW'(i)) rd_nxt = regq[i];
    end
    if (id_hit) rd_nxt = id_val;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

  // R1
  rd_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0));

  // R6
  id_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ((addr == ADR_ID) && (regq[0] == '0) && (regq[1] == '0)) |=> (rd_data == ID_CODE));

  // R7
  rev_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ((addr == ADR_REV) && (regq[0] == '0) && (regq[1] == '0)) |=> (rd_data == REV_CODE));

  // R8
  id_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (id_hit && ((regq[0] | regq[1]) != '0)) |=> (rd_data == '0));

  // R5
  feat_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADR_FEAT)) |=> (regq[FEAT_IDX] == $past(wr_data)));
endmodule

// File: tb/test_ureg_lock_top.sv
module test_ureg_lock_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m [9];

  always #2 clk = ~clk;

  ureg_lock_top i_ureg_lock_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [7:0] pmask(int a);
    case (a)
      2: return 8'hF0;
      3: return 8'h30;
      4: return 8'h30;
      5: return 8'hE0;
      7: return 8'hFF;
      8: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    if (a < 9) return m[a];
    if (a == 9)  return (m[0] == 0 && m[1] == 0) ? 8'h04 : 8'h00;
    if (a == 10) return (m[0] == 0 && m[1] == 0) ? 8'h01 : 8'h00;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wr_data = d;
    if (a < 9) begin
      logic [7:0] pm = pmask(a);
      logic [7:0] pv = m[6][4] ? d : m[a];
      m[a] = (d & ~pm) | (pv & pm);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, int a);
    @(negedge clk);
    wr_en = 1'b0; addr = 4'(a);
    @(negedge clk);
    chk(req, rd_data, exp_rd(a));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0651);
    for (int i = 0; i < 9; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 8'h00);
    for (int a = 0; a < 16; a++) rd("R1 reset values", a);

    // R10: rd_data holds until the next edge
    rd("R10 setup", 9);
    @(negedge clk); addr = 4'd2; #1;
    chk("R10 no change before edge", rd_data, 8'h04);
    @(negedge clk);
    chk("R10 update after edge", rd_data, 8'h00);

    // R2 / R4 locked writes
    wr(2, 8'hFF); rd("R2 R4 ier locked", 2);
    wr(7, 8'hA5); rd("R4 aux A locked", 7);
    wr(5, 8'hFF); rd("R2 R4 mcr locked", 5);
    // R5 / R3 unlock
    wr(6, 8'h30); rd("R5 feature readback", 6);
    wr(2, 8'hFF); rd("R3 ier unlocked", 2);
    wr(8, 8'h5A); rd("R3 aux B unlocked", 8);
    wr(3, 8'h3C); rd("R3 fifo ctl unlocked", 3);
    // R5 relock, then R4 hold
    wr(6, 8'h20); rd("R5 feature relock", 6);
    wr(2, 8'h00); rd("R4 ier frozen", 2);
    wr(8, 8'h00); rd("R4 aux B frozen", 8);
    wr(4, 8'hFF); rd("R2 R4 status cfg", 4);
    // R9 read-only and unmapped
    wr(9, 8'hFF); wr(12, 8'h77);
    rd("R6 id after write attempt", 9);
    rd("R7 rev", 10);
    rd("R9 unmapped read", 12);
    for (int a = 0; a < 9; a++) rd("R9 no register touched", a);
    // R8 divisor gating
    wr(0, 8'h01); rd("R8 id hidden lo", 9); rd("R8 rev hidden lo", 10);
    wr(0, 8'h00); wr(1, 8'h80); rd("R8 id hidden hi", 9);
    wr(1, 8'h00); rd("R6 id back", 9); rd("R7 rev back", 10);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int a = int'($urandom % 16);
      logic [7:0] d = 8'($urandom);
      if ($urandom % 3 == 0) d = 8'h00;
      if ($urandom % 2 == 0) wr(a, d);
      rd("R2/R3/R4/R8 random", int'($urandom % 16));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule